// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This block decides, within a single cycle, whether a conditional-trap instruction fires. Two 64-bit operands are compared five ways at once: signed less-than, signed greater-than, unsigned less-than, unsigned greater-than and equality. The five results form a flag vector. A 5-bit condition mask taken from the instruction selects which of those flags may raise the trap. A separate 5-bit exception-type vector from earlier pipeline stages forces the trap whenever any of its bits is set.

When the word-mode input is high, only the low 32 bits of each operand take part. The signed comparisons see those bits sign-extended. The unsigned comparisons and the equality test see them zero-extended. The block is purely combinational and has no clock or reset. Decoding, saving machine state on trap entry and computing the handler address are handled elsewhere.

Top module: `trap_cmp_unit`

## Requirements
- R1: `cmp_flags_o` bit positions are fixed: bit 0 unsigned greater-than, bit 1 unsigned less-than, bit 2 equal, bit 3 signed greater-than, bit 4 signed less-than.
- R2: With `word_mode_i` low, bits 4 and 3 give the two's-complement ordering of the full 64-bit operands `opa_i` against `opb_i`.
- R3: With `word_mode_i` low, bits 1 and 0 give the unsigned ordering of the full 64-bit operands.
- R4: Bit 2 is set exactly when the compared operands are equal. Among {signed lt, signed gt, equal} exactly one flag is set, and the same holds among {unsigned lt, unsigned gt, equal}.
- R5: With `word_mode_i` high, the signed flags compare bits 31:0 of each operand after sign-extension from bit 31.
- R6: With `word_mode_i` high, the unsigned flags and the equal flag compare bits 31:0 zero-extended. Bits 63:32 then have no effect, so operands that differ only there compare equal.
- R7: `take_trap_o` is high when `cmp_flags_o & cond_mask_i` is nonzero. Each mask bit enables the flag at the same position.
- R8: `take_trap_o` is high whenever `exc_type_i` is nonzero, whatever the operands and the mask.
- R9: With `cond_mask_i` and `exc_type_i` both zero, `take_trap_o` is low.
- R10: Outputs depend only on the current inputs, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| word_mode_i | input | 1 | 1 = compare the low 32 bits only |
| cond_mask_i | input | 5 | Condition mask, one bit per flag |
| exc_type_i | input | 5 | Pending exception type; any set bit forces a trap |
| take_trap_o | output | 1 | Trap decision |
| cmp_flags_o | output | 5 | Comparison flags in the R1 order |

## Verification
Operand pairs are chosen so that the signed and unsigned orderings disagree, such as a negative value against a small positive one. Each single-bit mask then shows which flag position it selects. Sign-bit boundaries at bit 63 and bit 31 are applied in both modes, which tells 64-bit behaviour apart from narrowed behaviour. Pairs that differ only in the upper half confirm that word mode ignores those bits. Random operands with random masks and exception types, half of them with equal low words, are then compared against a behavioural model written with native signed and unsigned integers.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;
  localparam int unsigned NFLAG   = 5;
  localparam int unsigned FLAG_UGT = 0;
  localparam int unsigned FLAG_ULT = 1;
  localparam int unsigned FLAG_EQ  = 2;
  localparam int unsigned FLAG_SGT = 3;
  localparam int unsigned FLAG_SLT = 4;
  localparam int unsigned NOPND   = 2;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/trap_cmp_narrow.sv
module trap_cmp_narrow #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned HALF_W = 32
) (
  input  logic [trap_cmp_pkg::NOPND-1:0][DATA_W-1:0] opnd_i,
  input  logic                                       word_mode_i,
  output logic [trap_cmp_pkg::NOPND-1:0][DATA_W-1:0] sx_o,
  output logic [trap_cmp_pkg::NOPND-1:0][DATA_W-1:0] zx_o
);
  localparam int unsigned EXT_W = DATA_W - HALF_W;

  for (genvar g = 0; g < int'(trap_cmp_pkg::NOPND); g++) begin : g_opnd
    logic [HALF_W-1:0] low;
    assign low = opnd_i[g][HALF_W-1:0];
    always_comb begin
      if (word_mode_i) begin
        sx_o[g] = {{EXT_W{low[HALF_W-1]}}, low};
        zx_o[g] = {{EXT_W{1'b0}}, low};
      end else begin
        sx_o[g] = opnd_i[g];
        zx_o[g] = opnd_i[g];
      end
    end
  end
endmodule

// File: rtl/trap_cmp_compare.sv
module trap_cmp_compare
  import trap_cmp_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [NOPND-1:0][DATA_W-1:0] sx_i,
  input  logic [NOPND-1:0][DATA_W-1:0] zx_i,
  output flag_vec_t                    flags_o
);
  always_comb begin
    flags_o           = '0;
    flags_o[FLAG_SLT] = $signed(sx_i[0]) < $signed(sx_i[1]);
    flags_o[FLAG_SGT] = $signed(sx_i[0]) > $signed(sx_i[1]);
    flags_o[FLAG_ULT] = zx_i[0] < zx_i[1];
    flags_o[FLAG_UGT] = zx_i[0] > zx_i[1];
    flags_o[FLAG_EQ]  = zx_i[0] == zx_i[1];
  end

  // R4: ordering trichotomy on both signed and unsigned views
  always_comb begin
    a_r4_signed_tri: assert ($countones({flags_o[FLAG_SLT], flags_o[FLAG_SGT], flags_o[FLAG_EQ]}) == 1)
      else $error("a_r4_signed_tri");
    a_r4_unsigned_tri: assert ($countones({flags_o[FLAG_ULT], flags_o[FLAG_UGT], flags_o[FLAG_EQ]}) == 1)
      else $error("a_r4_unsigned_tri");
  end
endmodule

// File: rtl/trap_cmp_decide.sv
module trap_cmp_decide
  import trap_cmp_pkg::*;
#(
  parameter int unsigned XTYPE_W = 5
) (
  input  flag_vec_t          flags_i,
  input  flag_vec_t          mask_i,
  input  logic [XTYPE_W-1:0] exc_type_i,
  output logic               take_o
);
  logic cond_hit;
  assign cond_hit = |(flags_i & mask_i);
  assign take_o   = cond_hit | (|exc_type_i);

  always_comb begin
    a_r8_exc_forces: assert (exc_type_i == '0 || take_o)
      else $error("a_r8_exc_forces");
    a_r9_idle_quiet: assert (!(mask_i == '0 && exc_type_i == '0) || !take_o)
      else $error("a_r9_idle_quiet");
  end
endmodule

// File: rtl/trap_cmp_unit.sv
module trap_cmp_unit
  import trap_cmp_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned HALF_W  = 32,
  parameter int unsigned XTYPE_W = 5
) (
  input  logic [DATA_W-1:0]  opa_i,
  input  logic [DATA_W-1:0]  opb_i,
  input  logic               word_mode_i,
  input  logic [NFLAG-1:0]   cond_mask_i,
  input  logic [XTYPE_W-1:0] exc_type_i,
  output logic               take_trap_o,
  output logic [NFLAG-1:0]   cmp_flags_o
);
  logic [NOPND-1:0][DATA_W-1:0] opnd, sx, zx;
  flag_vec_t flags;

  assign opnd[0] = opa_i;
  assign opnd[1] = opb_i;

  trap_cmp_narrow #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_narrow (
    .opnd_i      (opnd),
    .word_mode_i (word_mode_i),
    .sx_o        (sx),
    .zx_o        (zx)
  );

  trap_cmp_compare #(.DATA_W(DATA_W)) u_cmp (
    .sx_i    (sx),
    .zx_i    (zx),
    .flags_o (flags)
  );

  trap_cmp_decide #(.XTYPE_W(XTYPE_W)) u_dec (
    .flags_i    (flags),
    .mask_i     (cond_mask_i),
    .exc_type_i (exc_type_i),
    .take_o     (take_trap_o)
  );

  assign cmp_flags_o = flags;

  // R6: word mode equality depends on the low half alone
  always_comb begin
    a_r6_word_eq: assert (!word_mode_i ||
                          (flags[FLAG_EQ] == (opa_i[HALF_W-1:0] == opb_i[HALF_W-1:0])))
      else $error("a_r6_word_eq");
    a_r4_full_eq: assert (word_mode_i || (flags[FLAG_EQ] == (opa_i == opb_i)))
      else $error("a_r4_full_eq");
  end
endmodule

// File: tb/trap_cmp_unit_test.sv
module trap_cmp_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] opa, opb;
  logic        wmode;
  logic [4:0]  mask, exc;
  logic        take;
  logic [4:0]  flags;
  int          n_chk = 0, n_fail = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  trap_cmp_unit uut (
    .opa_i(opa), .opb_i(opb), .word_mode_i(wmode),
    .cond_mask_i(mask), .exc_type_i(exc),
    .take_trap_o(take), .cmp_flags_o(flags)
  );

  function automatic logic [4:0] model_flags(logic [63:0] a, logic [63:0] b, logic w);
    longint          sa, sb;
    longint unsigned ua, ub;
    logic [4:0]      f;
    sa = w ? longint'(int'(a[31:0])) : longint'(a);
    sb = w ? longint'(int'(b[31:0])) : longint'(b);
    ua = w ? longint'(a[31:0]) : a;
    ub = w ? longint'(b[31:0]) : b;
    f[0] = ua > ub;
    f[1] = ua < ub;
    f[2] = ua == ub;
    f[3] = sa > sb;
    f[4] = sa < sb;
    return f;
  endfunction

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic w,
                       input logic [4:0] m, input logic [4:0] x, input string tag);
    logic [4:0] ef;
    logic       et;
    @(negedge clk);
    opa = a; opb = b; wmode = w; mask = m; exc = x;
    #1;
    ef = model_flags(a, b, w);
    et = ((ef & m) != 0) || (x != 0);
    n_chk++;
    if (flags !== ef) begin
      n_fail++;
      $display("FAIL %s flags a=%h b=%h w=%0b actual=%b expected=%b", tag, a, b, w, flags, ef);
    end
    n_chk++;
    if (take !== et) begin
      n_fail++;
      $display("FAIL %s take a=%h b=%h m=%b x=%b actual=%b expected=%b", tag, a, b, m, x, take, et);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] pa [6];
    logic [63:0] pb [6];
    opa = '0; opb = '0; wmode = 1'b0; mask = '0; exc = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R10 R9: idle state, equal zero operands, no trap
    apply(64'd0, 64'd0, 1'b0, 5'b0, 5'b0, "R10 R9 idle");
    // R1 R7: each mask bit alone over pairs where signed and unsigned disagree
    pa = '{64'd5, 64'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd9, 64'h8000_0000_0000_0000};
    pb = '{64'd3, 64'd5, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd9, 64'h7FFF_FFFF_FFFF_FFFF};
    for (int p = 0; p < 6; p++)
      for (int k = 0; k < 5; k++)
        apply(pa[p], pb[p], 1'b0, 5'(1 << k), 5'b0, "R1 R7 single mask bit");
    // R2 R3: 64-bit sign boundary
    apply(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 5'b11111, 5'b0, "R2 R3 bit63 edge");
    apply(64'h0000_0000_8000_0000, 64'd1, 1'b0, 5'b01000, 5'b0, "R2 positive in 64-bit");
    // R5: same pair in word mode is negative
    apply(64'h0000_0000_8000_0000, 64'd1, 1'b1, 5'b10000, 5'b0, "R5 bit31 sign");
    apply(64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0000_8000_0000, 1'b1, 5'b01001, 5'b0, "R5 R6 word boundary");
    // R6: upper half ignored
    apply(64'hDEAD_BEEF_0000_0005, 64'h1234_5678_0000_0005, 1'b1, 5'b00100, 5'b0, "R6 upper ignored eq");
    apply(64'hDEAD_BEEF_0000_0005, 64'h1234_5678_0000_0005, 1'b1, 5'b11011, 5'b0, "R6 upper ignored no order");
    apply(64'h0000_0001_0000_0000, 64'd0, 1'b1, 5'b00100, 5'b0, "R6 R4 only upper differs");
    // R8: exception types force trap regardless of mask
    for (int k = 0; k < 5; k++)
      apply(64'd1, 64'd2, 1'b0, 5'b0, 5'(1 << k), "R8 exception forces");
    apply(64'd7, 64'd7, 1'b0, 5'b11011, 5'b10001, "R8 exception with miss");
    // R9: zero mask with any operands
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, 5'b0, 5'b0, "R9 zero mask");
    // R4 R2 R3 R5 R6 R7 R8: random sweep
    for (int i = 0; i < 400; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (i % 2 == 0) rb[31:0] = ra[31:0];
      apply(ra, rb, 1'($urandom), 5'($urandom), (i % 4 == 1) ? 5'($urandom) : 5'b0, "R4 random");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule